// File: doc/BRIEF.md
# Trigger Glitch Filter

This block cleans up a small group of asynchronous trigger inputs before the logic that starts conversions sees them. A two-flop synchroniser brings each raw input onto the system clock. A per-input counter then holds the filtered level until the synchronised input has stayed at its new value for a programmable number of clocks. Pulses narrower than that window are dropped. Every change of a filtered level also produces a one-clock rise or fall pulse. Consumers can therefore trigger on an edge, or gate on the level itself.

The window length comes from a 4-bit exponent code held in a 32-bit memory-mapped register. The required stable time is 2^code + 1 clocks, which ranges from 2 to 32769 clocks. Changing the window while a consumer is running would corrupt its triggering. For that reason the register refuses writes whenever the consumer-enable flag is high.

Top module: `trig_glitch_filter`

## Requirements
- R1: After reset the length code is 0. A read at byte offset 0x0C returns the code in bits 3:0, with bits 31:4 zero. A read at any other offset returns 0.
- R2: A write at offset 0x0C while `consumer_en` is low loads bits 3:0 of the write data into the code. The upper write bits are ignored, and a write at any other offset changes nothing.
- R3: A write while `consumer_en` is high leaves the code at its previous value.
- R4: The required stable length for code c is 2^c + 1 clocks. For example, code 0 gives 2, code 3 gives 9 and code 15 gives 32769.
- R5: A raw pulse held for fewer clocks than the required length leaves the filtered level and the edge outputs unchanged. A pulse held for at least the length is accepted.
- R6: An accepted change appears on the filtered level at the (2 + length)-th rising clock edge after the raw input changed. The first two edges are taken by the synchroniser.
- R7: Every 0-to-1 change of a filtered level gives exactly one one-clock pulse on its rise output. Every 1-to-0 change gives exactly one one-clock pulse on its fall output. Rise and fall are never high together.
- R8: Filtered levels and edge outputs are 0 during and after reset.
- R9: Each input is filtered independently. Activity on one input never moves another input's outputs.
- R10: If the synchronised input returns to the filtered level, even for one clock, the stable-time count restarts. Two sub-length pulses with a one-clock gap between them are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| consumer_en | input | 1 | High while any trigger consumer is enabled; locks the length code |
| trig_raw | input | 4 | Asynchronous raw trigger inputs |
| trig_level | output | 4 | Filtered trigger levels |
| trig_rise | output | 4 | One-clock pulse on each filtered rising change |
| trig_fall | output | 4 | One-clock pulse on each filtered falling change |

## Verification
On every cycle, the assertions check the following:
- the write lock and the write-apply rule of the length register;
- the reserved read bits;
- the shape of the edge pulses, which must last one clock, never overlap, and agree with the level's movement;
- the rule that a filtered level never moves without a matching pulse.

The exact acceptance threshold of 2^code + 1 can only be shown by the bench's scenarios. The same holds for the (2 + length) latency, for count restarts after an interrupted pulse, and for the independence of channels. The bench drives pulses of chosen widths and compares pulse counts and arrival cycles against its own computation of the window.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

    // Width of the register data path
    localparam int REG_W = 32;

    // Stable-time length in clocks for an exponent code: 2^code + 1
    function automatic int unsigned stable_len(input int unsigned code);
        return (32'd1 << code) + 32'd1;
    endfunction

endpackage

// File: rtl/tgf_len_reg.sv
module tgf_len_reg #(
    parameter int                CODE_W     = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] LEN_OFFSET = 'h0C
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        wcode,
    input  logic                     locked,
    output logic [tgf_pkg::REG_W-1:0] rdata,
    output logic [CODE_W-1:0]        len_code
);
    import tgf_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } len_state_t;

    len_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = (addr == LEN_OFFSET);
        if (wr_en && hit && !locked) begin
            st_d.code = wcode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_code = st_q.code;
    assign rdata    = hit ? {{(REG_W-CODE_W){1'b0}}, st_q.code} : '0;

endmodule

// File: rtl/tgf_sync.sv
module tgf_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/tgf_chan.sv
module tgf_chan #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [CODE_W-1:0] len_code,
    output logic              level,
    output logic              rise,
    output logic              fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             rise;
        logic             fall;
    } chan_state_t;

    chan_state_t      st_d, st_q;
    logic [CNT_W-1:0] req_len;
    logic [CNT_W-1:0] cnt_inc;

    // Required stable length: 2^code + 1 clocks
    assign req_len = (CNT_W'(1) << len_code) + CNT_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        cnt_inc   = st_q.cnt + CNT_W'(1);
        if (sync_in == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= req_len) begin
            st_d.cnt  = '0;
            st_d.lvl  = sync_in;
            st_d.rise = sync_in;
            st_d.fall = !sync_in;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
    assign rise  = st_q.rise;
    assign fall  = st_q.fall;

endmodule

// File: rtl/trig_glitch_filter.sv
module trig_glitch_filter #(
    parameter int                NUM_TRIG   = 4,
    parameter int                CODE_W     = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] LEN_OFFSET = 'h0C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                consumer_en,
    input  logic [NUM_TRIG-1:0] trig_raw,
    output logic [NUM_TRIG-1:0] trig_level,
    output logic [NUM_TRIG-1:0] trig_rise,
    output logic [NUM_TRIG-1:0] trig_fall
);
    // Counter must hold the longest length, 2^(2^CODE_W - 1) + 1
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = $clog2((1 << MAX_CODE) + 2);

    logic [CODE_W-1:0]   len_code;
    logic [NUM_TRIG-1:0] trig_sync;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[31:CODE_W];

    tgf_len_reg #(
        .CODE_W    (CODE_W),
        .ADDR_W    (ADDR_W),
        .LEN_OFFSET(LEN_OFFSET)
    ) u_len_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wcode   (reg_wdata[CODE_W-1:0]),
        .locked  (consumer_en),
        .rdata   (reg_rdata),
        .len_code(len_code)
    );

    tgf_sync #(.WIDTH(NUM_TRIG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(trig_raw),
        .sync_out(trig_sync)
    );

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_chan
        tgf_chan #(
            .CODE_W(CODE_W),
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (trig_sync[g]),
            .len_code(len_code),
            .level   (trig_level[g]),
            .rise    (trig_rise[g]),
            .fall    (trig_fall[g])
        );
    end

endmodule

// File: rtl/tgf_chk.sv
module tgf_chk #(
    parameter int                NUM_TRIG   = 4,
    parameter int                CODE_W     = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] LEN_OFFSET = 'h0C
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic                consumer_en,
    input logic [CODE_W-1:0]   len_code,
    input logic [NUM_TRIG-1:0] trig_level,
    input logic [NUM_TRIG-1:0] trig_rise,
    input logic [NUM_TRIG-1:0] trig_fall
);
    // R3
    wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && consumer_en) |=> $stable(len_code));

    // R2
    wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !consumer_en && reg_addr == LEN_OFFSET)
        |=> (len_code == $past(reg_wdata[CODE_W-1:0])));

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:CODE_W] == '0);

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_chk
        // R7
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trig_rise[g] |=> !trig_rise[g]);
        // R7
        fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trig_fall[g] |=> !trig_fall[g]);
        // R7
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(trig_rise[g] && trig_fall[g]));
        // R7
        rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trig_rise[g] |-> (trig_level[g] && !$past(trig_level[g])));
        // R7
        fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trig_fall[g] |-> (!trig_level[g] && $past(trig_level[g])));
        // R5
        level_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_level[g] != $past(trig_level[g])) |-> (trig_rise[g] || trig_fall[g]));
    end

endmodule

bind trig_glitch_filter tgf_chk #(
    .NUM_TRIG  (NUM_TRIG),
    .CODE_W    (CODE_W),
    .ADDR_W    (ADDR_W),
    .LEN_OFFSET(LEN_OFFSET)
) u_tgf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .consumer_en(consumer_en),
    .len_code   (len_code),
    .trig_level (trig_level),
    .trig_rise  (trig_rise),
    .trig_fall  (trig_fall)
);

// File: tb/trig_glitch_filter_bench.sv
module trig_glitch_filter_bench;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          consumer_en = 1'b0;
    logic [NT-1:0] trig_raw = '0;
    logic [NT-1:0] trig_level, trig_rise, trig_fall;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int rise_n [NT];
    int fall_n [NT];
    int rise_at[NT];
    int fall_at[NT];

    trig_glitch_filter u_trig_glitch_filter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .consumer_en(consumer_en),
        .trig_raw(trig_raw), .trig_level(trig_level), .trig_rise(trig_rise),
        .trig_fall(trig_fall)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NT; i++) begin
                if (trig_rise[i]) begin rise_n[i] = rise_n[i] + 1; rise_at[i] = cyc; end
                if (trig_fall[i]) begin fall_n[i] = fall_n[i] + 1; fall_at[i] = cyc; end
            end
        end
    end

    function automatic int exp_len(input int code);
        return (1 << code) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        for (int i = 0; i < NT; i++) begin
            rise_n[i] = 0; fall_n[i] = 0; rise_at[i] = -1; fall_at[i] = -1;
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h0C;
    endtask

    task automatic reg_read(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
        reg_addr = 8'h0C;
    endtask

    task automatic set_code(input int code);
        int v;
        reg_write(8'h0C, 32'(code));
        reg_read(8'h0C, v);
        check(v == code, "R2", v, code);
    endtask

    // Drive one pulse of width w on channel ch and check against window len
    task automatic pulse_trial(input int ch, input int w, input int len);
        int c0;
        bit pass;
        int others;
        clear_mon();
        @(negedge clk);
        c0 = cyc;
        trig_raw[ch] = 1'b1;
        repeat (w) @(negedge clk);
        trig_raw[ch] = 1'b0;
        repeat (len + 6) @(negedge clk);
        pass = (w >= len);
        check(rise_n[ch] == (pass ? 1 : 0), "R5", rise_n[ch], pass ? 1 : 0);
        check(fall_n[ch] == (pass ? 1 : 0), "R7", fall_n[ch], pass ? 1 : 0);
        if (pass) begin
            check(rise_at[ch] == c0 + 2 + len, "R6", rise_at[ch], c0 + 2 + len);
            check(fall_at[ch] == c0 + w + 2 + len, "R6", fall_at[ch], c0 + w + 2 + len);
        end
        others = 0;
        for (int i = 0; i < NT; i++)
            if (i != ch) others += rise_n[i] + fall_n[i] + int'(trig_level[i]);
        check(others == 0, "R9", others, 0);
        check(trig_level == '0, "R8", int'(trig_level), 0);
    endtask

    initial begin
        int v;
        int code;
        int len;
        clear_mon();
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        check(trig_level == '0 && trig_rise == '0 && trig_fall == '0, "R8",
              int'({trig_level, trig_rise, trig_fall}), 0);
        rst_n = 1'b1;
        // R1: reset code and read map
        reg_read(8'h0C, v); check(v == 0, "R1", v, 0);
        reg_read(8'h08, v); check(v == 0, "R1", v, 0);
        // R2: upper write bits dropped
        reg_write(8'h0C, 32'hFFFF_FFF5);
        reg_read(8'h0C, v); check(v == 5, "R2", v, 5);
        reg_read(8'h10, v); check(v == 0, "R1", v, 0);
        // R2: write at another offset ignored
        reg_write(8'h04, 32'h0000_0002);
        reg_read(8'h0C, v); check(v == 5, "R2", v, 5);
        // R3: locked while a consumer is enabled
        consumer_en = 1'b1;
        reg_write(8'h0C, 32'h0000_0007);
        reg_read(8'h0C, v); check(v == 5, "R3", v, 5);
        consumer_en = 1'b0;
        // R4/R5: code 0 boundary (length 2)
        set_code(0);
        pulse_trial(0, 1, exp_len(0));
        pulse_trial(0, 2, exp_len(0));
        // R4: code 3 boundary (length 9)
        set_code(3);
        pulse_trial(1, 8, exp_len(3));
        pulse_trial(1, 9, exp_len(3));
        // R10: two 8-clock pulses with a one-clock gap are rejected
        clear_mon();
        @(negedge clk);
        trig_raw[2] = 1'b1; repeat (8) @(negedge clk);
        trig_raw[2] = 1'b0; @(negedge clk);
        trig_raw[2] = 1'b1; repeat (8) @(negedge clk);
        trig_raw[2] = 1'b0; repeat (20) @(negedge clk);
        check(rise_n[2] == 0, "R10", rise_n[2], 0);
        check(trig_level == '0, "R10", int'(trig_level), 0);
        // Constrained random widths around the window
        for (int t = 0; t < 40; t++) begin
            code = int'($urandom_range(5, 0));
            len  = exp_len(code);
            set_code(code);
            pulse_trial(int'($urandom_range(NT - 1, 0)), int'($urandom_range(len + 3, 1)), len);
        end
        // R4: long windows
        set_code(12);
        pulse_trial(3, 4096, exp_len(12));
        set_code(15);
        pulse_trial(2, 32769, exp_len(15));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule